// File: doc/BRIEF.md
# Iterative Logarithmic Approximate Multiplier

This block multiplies two unsigned integers using only leading-one detection, shifts and additions, without an array multiplier. Each operand is split into its highest set bit and the bits below it, called the residue. For residues x = 2^j + xr and y = 2^k + yr, the partial product 2^(j+k) + (yr << j) + (xr << k) is added to an accumulator. The residue product xr·yr, which this partial product leaves out, is then handled in the same way on the next iteration.

One iteration runs per clock cycle. A caller supplies two operands and an iteration limit, then pulses `start`. The run ends when either residue reaches zero or when the limit is used up. The accumulator is exposed as `product` and is held there. A small limit gives a cheap under-estimate: about −25% worst case after one pass, about −6% after two and about −1.6% after three. A limit of at least the operand width always gives the exact product.

Top module: `logmul_iter`

## Requirements
- R1: While reset is asserted and after it is released, `product` is 0 and `done` is 0 until a run finishes.
- R2: When `start` is sampled high while idle, `done` goes high for exactly one cycle, n+1 clock cycles after that edge. Here n = min(popcount(a), popcount(b), iter_limit).
- R3: When iter_limit is at least the operand width W, `product` equals a·b when `done` is high.
- R4: For any iter_limit, `product` never exceeds a·b when `done` is high.
- R5: Each iteration adds 2^(j+k) + (yr << j) + (xr << k) to the accumulator, where j and k are the leading-one positions of the current residues x and y, and xr = x − 2^j, yr = y − 2^k. For example, 255·255 gives 48896 with limit 1, 61056 with limit 2 and 64064 with limit 3.
- R6: If either operand is zero, `product` is 0 and `done` follows one cycle after the start edge.
- R7: An iteration limit of 0 yields `product` 0 and `done` one cycle after the start edge.
- R8: A `start` pulse that arrives while a run is in progress is ignored. The run completes with the original operands and its original timing.
- R9: After `done`, `product` holds its value until the next accepted `start`, whatever `a`, `b` and `iter_limit` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a multiplication with the present operands and limit |
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| iter_limit | input | LW | Maximum number of refinement iterations |
| product | output | 2W | Accumulated product, final when done is high |
| done | output | 1 | One-cycle pulse when the result is final |

## Verification
The hardest case to reach is a run that lasts a full W iterations. This happens only when both operands have every bit set, so that each step peels exactly one bit from each residue and the last step multiplies 1 by 1. The stimulus drives 255·255 at several limits and checks both the partial sums and the exact final value. A second hard case is a `start` pulse arriving mid-run. The bench raises start with different operands on the second busy cycle of a long run, then checks that the result and the latency belong to the first request.

// File: rtl/logmul_pkg.sv
package logmul_pkg;
  function automatic int unsigned idx_bits(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/logmul_rst_sync.sv
module logmul_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/logmul_lod.sv
module logmul_lod #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int unsigned i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/logmul_term.sv
module logmul_term #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3,
  localparam int unsigned PW = 2 * W
) (
  input  logic [W-1:0]  res_x,
  input  logic [W-1:0]  res_y,
  output logic [W-1:0]  rem_x,
  output logic [W-1:0]  rem_y,
  output logic [PW-1:0] term
);
  logic [IW-1:0] pos_x, pos_y;
  logic [IW:0]   pos_sum;

  logmul_lod #(.W(W), .IW(IW)) i_lod_x (.vec(res_x), .idx(pos_x));
  logmul_lod #(.W(W), .IW(IW)) i_lod_y (.vec(res_y), .idx(pos_y));

  assign rem_x   = res_x ^ (W'(1) << pos_x);
  assign rem_y   = res_y ^ (W'(1) << pos_y);
  assign pos_sum = {1'b0, pos_x} + {1'b0, pos_y};
  assign term    = (PW'(1) << pos_sum) + (PW'(rem_y) << pos_x) + (PW'(rem_x) << pos_y);
endmodule

// File: rtl/logmul_iter.sv
module logmul_iter #(
  parameter int unsigned W  = 8,
  parameter int unsigned LW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [LW-1:0]     iter_limit,
  output logic [2*W-1:0]    product,
  output logic              done
);
  import logmul_pkg::*;
  localparam int unsigned PW = 2 * W;
  localparam int unsigned IW = idx_bits(W);

  logic          rst_sync_n;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [W-1:0]  res_x_q, res_x_d, res_y_q, res_y_d;
  logic [PW-1:0] acc_q, acc_d;
  logic [LW-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [W-1:0]  rem_x, rem_y;
  logic [PW-1:0] term;
  logic          finish, load_en, step_en;

  logmul_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  logmul_term #(.W(W), .IW(IW)) i_term (
    .res_x(res_x_q), .res_y(res_y_q), .rem_x(rem_x), .rem_y(rem_y), .term(term)
  );

  assign finish  = busy_q && ((res_x_q == '0) || (res_y_q == '0) || (cnt_q == lim_q));
  assign step_en = busy_q && !finish;
  assign load_en = !busy_q && start;

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    res_x_d = res_x_q;
    res_y_d = res_y_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    if (load_en) begin
      busy_d  = 1'b1;
      res_x_d = a;
      res_y_d = b;
      acc_d   = '0;
      cnt_d   = '0;
      lim_d   = iter_limit;
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (step_en) begin
      res_x_d = rem_x;
      res_y_d = rem_y;
      acc_d   = acc_q + term;
      cnt_d   = cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_x_q <= '0;
      res_y_q <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (load_en || step_en) begin
        res_x_q <= res_x_d;
        res_y_q <= res_y_d;
        acc_q   <= acc_d;
        cnt_q   <= cnt_d;
      end
      if (load_en) lim_q <= lim_d;
    end
  end

  assign product = acc_q;
  assign done    = done_q;
endmodule

// File: rtl/logmul_iter_chk.sv
module logmul_iter_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned LW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [LW-1:0]  iter_limit,
  input logic [2*W-1:0] product,
  input logic           done
);
  logic [W-1:0]  cap_a, cap_b;
  logic [LW-1:0] cap_lim;
  logic [2*W-1:0] true_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      cap_lim <= '0;
    end else if (start && !busy) begin
      cap_a   <= a;
      cap_b   <= b;
      cap_lim <= iter_limit;
    end
  end

  assign true_p = (2*W)'(cap_a) * (2*W)'(cap_b);

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (32'(cap_lim) >= W)) |-> (product == true_p));
  a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product <= true_p));
  a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ((cap_a == '0) || (cap_b == '0))) |-> (product == '0));
  a_r7_limit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cap_lim == '0)) |-> (product == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind logmul_iter logmul_iter_chk #(.W(W), .LW(LW)) i_logmul_iter_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .busy(busy_q), .a(a), .b(b),
  .iter_limit(iter_limit), .product(product), .done(done)
);

// File: tb/test_logmul_iter.sv
module test_logmul_iter;
  localparam int W  = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic [LW-1:0] iter_limit = '0;
  logic [2*W-1:0] product;
  logic          done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  logmul_iter #(.W(W), .LW(LW)) i_logmul_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .iter_limit(iter_limit), .product(product), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int msb(input int v);
    int r = 0;
    for (int i = 0; i < W; i++) if (v[i]) r = i;
    return r;
  endfunction

  // R5 formula applied up to the limit
  function automatic int model(input int x, input int y, input int l);
    int acc = 0;
    for (int n = 0; n < l; n++) begin
      int j, k, xr, yr;
      if (x == 0 || y == 0) break;
      j = msb(x); k = msb(y);
      xr = x - (1 << j); yr = y - (1 << k);
      acc += (1 << (j + k)) + (yr << j) + (xr << k);
      x = xr; y = yr;
    end
    return acc;
  endfunction

  function automatic int min3(input int p, input int q, input int r);
    int m = p;
    if (q < m) m = q;
    if (r < m) m = r;
    return m;
  endfunction

  task automatic run(input int x, input int y, input int l,
                     output int p, output int cyc, input bit poke = 0);
    @(negedge clk);
    a = W'(x); b = W'(y); iter_limit = LW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    p = -1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 1) begin
        a = 8'h0F; b = 8'h03; iter_limit = 4'd1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        p = int'(product);
        break;
      end
    end
    if (p < 0) chk("R2 done timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 product in reset", product, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 product after reset", product, 0);
    chk("R1 done after reset", done, 0);
  endtask

  task automatic t_exact_sweep();
    int p, c;
    for (int x = 0; x < 256; x += 17) begin
      for (int y = 3; y < 256; y += 29) begin
        int l = (x + y) % 2 ? 8 : 15;
        run(x, y, l, p, c);
        chk("R3 exact product", p, x * y);
        chk("R2 latency", c, min3($countones(x), $countones(y), l) + 1);
      end
    end
    run(255, 255, 8, p, c);
    chk("R3 exact 255x255", p, 65025);
    chk("R2 latency 255x255", c, 9);
  endtask

  task automatic t_low_limits();
    int p, c;
    int exp255[4] = '{0, 48896, 61056, 64064};
    for (int l = 1; l <= 3; l++) begin
      run(255, 255, l, p, c);
      chk("R5 255x255 partial", p, exp255[l]);
      chk("R2 latency partial", c, l + 1);
    end
    for (int x = 1; x < 256; x += 23) begin
      for (int y = 5; y < 256; y += 37) begin
        for (int l = 1; l < 7; l += 2) begin
          run(x, y, l, p, c);
          chk("R5 iteration sum", p, model(x, y, l));
          chk("R4 not above true product", (p <= x * y) ? 1 : 0, 1);
        end
      end
    end
  endtask

  task automatic t_zero();
    int p, c;
    run(0, 200, 8, p, c);
    chk("R6 zero a product", p, 0);
    chk("R6 zero a latency", c, 1);
    run(77, 0, 8, p, c);
    chk("R6 zero b product", p, 0);
    chk("R6 zero b latency", c, 1);
  endtask

  task automatic t_limit0();
    int p, c;
    run(200, 150, 0, p, c);
    chk("R7 limit zero product", p, 0);
    chk("R7 limit zero latency", c, 1);
  endtask

  task automatic t_busy_start();
    int p, c;
    run(255, 254, 8, p, c, 1);
    chk("R8 result of first request", p, 255 * 254);
    chk("R8 latency of first request", c, 8);
  endtask

  task automatic t_hold();
    int p, c;
    run(201, 99, 8, p, c);
    @(negedge clk);
    a = 8'hFF; b = 8'h11; iter_limit = 4'd2;
    repeat (5) @(negedge clk);
    chk("R9 product held", product, 201 * 99);
    chk("R2 done not repeated", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_exact_sweep();
    t_low_limits();
    t_zero();
    t_limit0();
    t_busy_start();
    t_hold();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule